// File: doc/BRIEF.md
# Chip-Enable-Clocked Static RAM Cycle Sequencer

This block sits between a host and a one-bit-wide static memory whose cycles are started by the falling edge of an active-low chip enable. The host asks for a read, a write or a read-modify-write through a valid/ready request port. The sequencer then drives the memory's chip enable, write enable, address and data-in pins. Every phase of each cycle lasts a number of clock cycles set by a timing input. The order of the two enable edges depends on the cycle type. A write lowers write enable before chip enable falls, so the device latches data on chip enable and never drives its output. A read-modify-write lowers chip enable first. The read bit goes back to the host, and the cycle waits as long as the host takes to supply the replacement bit. It then lowers write enable for the lead time before chip enable rises.

The sequencer also handles low-supply data retention. When the host raises a power-down request, any cycle in flight finishes. Chip enable is then parked high for a guard interval before standby is acknowledged. After the request drops, chip enable stays high for a recovery interval before new requests are accepted. The sequencer never drives the supply itself; it only exchanges the request and acknowledge.

Each timing input value N gives a phase of N clock cycles; a value of 0 is treated as 1.

Top module: `ram_cycle_seq`

## Requirements
- R1: While reset is held and at the first cycle after reset, mem_ce_n and mem_we_n are 1, pd_ack and rd_valid are 0, and req_ready is 1 when pd_req is 0.
- R2: For a write (req_op = 2'b01), mem_we_n is already low in the cycle before mem_ce_n falls. The device then stores the request's data bit at that address, and a later read returns it.
- R3: For a read (req_op = 2'b00, with 2'b11 treated as a read) and for a read-modify-write (req_op = 2'b10), mem_we_n is high when mem_ce_n falls. In a read-modify-write, mem_we_n falls only after mem_ce_n has been low for more than t_hold + t_access cycles.
- R4: mem_ce_n stays low for exactly t_hold + t_access cycles on a read and t_hold + t_lead cycles on a write. On a read-modify-write it stays low for t_hold + t_access + t_lead cycles plus the number of cycles spent waiting for the modify bit.
- R5: Whenever a bit is written, mem_we_n and mem_ce_n are both low for at least t_lead cycles before mem_ce_n rises. In a read-modify-write, mem_din equals mod_wdata when mem_we_n falls.
- R6: Between two memory cycles, mem_ce_n is high for at least t_precharge cycles.
- R7: The memory's output bit is captured when the access interval ends and returned on rd_data. rd_valid is high for exactly one cycle per read or read-modify-write.
- R8: mem_addr does not change while mem_ce_n is low.
- R9: When pd_req rises with no cycle in flight, pd_ack rises after exactly t_ppd cycles. mem_ce_n stays high throughout. While pd_req is high, req_ready is 0 and requests are ignored.
- R10: After pd_req falls, pd_ack falls, mem_ce_n stays high, and req_ready returns after exactly t_recover cycles.
- R11: A power-down request raised during a memory cycle lets that cycle finish with its full chip-enable-low time and its write committed. Only then does the power-down sequence begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_setup | input | CW | Address setup cycles before chip enable falls |
| t_hold | input | CW | Address hold cycles after chip enable falls |
| t_access | input | CW | Access time cycles |
| t_lead | input | CW | Write-enable-low lead cycles before chip enable rises |
| t_precharge | input | CW | Chip enable high time between cycles |
| t_ppd | input | CW | Guard cycles before standby is acknowledged |
| t_recover | input | CW | Chip enable high cycles after wake-up |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | AW | Bit address |
| req_wdata | input | 1 | Bit to write (write requests) |
| rd_valid | output | 1 | One-cycle pulse: rd_data valid |
| rd_data | output | 1 | Bit read from memory |
| mod_valid | input | 1 | Host supplies the replacement bit |
| mod_ready | output | 1 | Sequencer waits for the replacement bit |
| mod_wdata | input | 1 | Replacement bit for read-modify-write |
| pd_req | input | 1 | Power-down request; low means wake |
| pd_ack | output | 1 | Memory parked; supply may be lowered |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_din | output | 1 | Memory data in |
| mem_dout | input | 1 | Memory data out |

## Verification
The hardest situation to reach is a power-down request that arrives while a memory cycle is only partly done. Here the request must be held off without cutting the cycle short, and the write must still land. The bench issues a write by hand and raises pd_req in the next cycle, while the sequencer is still in address setup. It then checks the chip-enable-low length. After recovery it reads the bit back from a bench model of the memory. That model latches the address and data on the pin edges, so a wrong enable order or a shortened cycle shows up as bad read data.

// File: rtl/ram_seq_pkg.sv
package ram_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CE_LOW,
        ST_ACCESS_WAIT,
        ST_MODIFY_WAIT,
        ST_WE_LOW,
        ST_PRECHARGE,
        ST_PD_ENTRY,
        ST_STANDBY,
        ST_PD_RECOVER
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_RSVD  = 2'd3
    } seq_op_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ram_cycle_seq.sv
module ram_cycle_seq
    import ram_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] t_setup,
    input  logic [CW-1:0] t_hold,
    input  logic [CW-1:0] t_access,
    input  logic [CW-1:0] t_lead,
    input  logic [CW-1:0] t_precharge,
    input  logic [CW-1:0] t_ppd,
    input  logic [CW-1:0] t_recover,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wdata,
    output logic          rd_valid,
    output logic          rd_data,
    input  logic          mod_valid,
    output logic          mod_ready,
    input  logic          mod_wdata,
    input  logic          pd_req,
    output logic          pd_ack,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_din,
    input  logic          mem_dout
);

    typedef struct packed {
        seq_state_e    state;
        seq_op_e       op;
        logic          ce_n;
        logic          we_n;
        logic [AW-1:0] addr;
        logic          din;
        logic          rd_valid;
        logic          rd_data;
        logic          pd_ack;
    } seq_regs_t;

    localparam seq_regs_t RESET_REGS = '{
        state:    ST_IDLE,
        op:       OP_READ,
        ce_n:     1'b1,
        we_n:     1'b1,
        addr:     '0,
        din:      1'b0,
        rd_valid: 1'b0,
        rd_data:  1'b0,
        pd_ack:   1'b0
    };

    seq_regs_t     d, q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    // A phase of N cycles loads N-1; zero saturates to a single cycle.
    function automatic logic [CW-1:0] phase_len(input logic [CW-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (pd_req) begin
                    d.state  = ST_PD_ENTRY;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_ppd);
                end else if (req_valid) begin
                    d.op     = (req_op == OP_RSVD) ? OP_READ : seq_op_e'(req_op);
                    d.addr   = req_addr;
                    d.din    = req_wdata;
                    // early write: write enable leads chip enable
                    d.we_n   = (req_op != OP_WRITE);
                    d.state  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_setup);
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    d.ce_n   = 1'b0;
                    d.state  = ST_CE_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_hold);
                end
            end
            ST_CE_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (q.op == OP_WRITE) begin
                        d.state = ST_WE_LOW;
                        tmr_val = phase_len(t_lead);
                    end else begin
                        d.state = ST_ACCESS_WAIT;
                        tmr_val = phase_len(t_access);
                    end
                end
            end
            ST_ACCESS_WAIT: begin
                if (tmr_done) begin
                    d.rd_data  = mem_dout;
                    d.rd_valid = 1'b1;
                    if (q.op == OP_RMW) begin
                        d.state = ST_MODIFY_WAIT;
                    end else begin
                        d.ce_n   = 1'b1;
                        d.state  = ST_PRECHARGE;
                        tmr_load = 1'b1;
                        tmr_val  = phase_len(t_precharge);
                    end
                end
            end
            ST_MODIFY_WAIT: begin
                if (mod_valid) begin
                    d.din    = mod_wdata;
                    d.we_n   = 1'b0;
                    d.state  = ST_WE_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_lead);
                end
            end
            ST_WE_LOW: begin
                if (tmr_done) begin
                    d.ce_n   = 1'b1;
                    d.we_n   = 1'b1;
                    d.state  = ST_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_precharge);
                end
            end
            ST_PRECHARGE: begin
                if (tmr_done) begin
                    d.state = ST_IDLE;
                end
            end
            ST_PD_ENTRY: begin
                if (tmr_done) begin
                    d.state  = ST_STANDBY;
                    d.pd_ack = 1'b1;
                end
            end
            ST_STANDBY: begin
                if (!pd_req) begin
                    d.pd_ack = 1'b0;
                    d.state  = ST_PD_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = phase_len(t_recover);
                end
            end
            ST_PD_RECOVER: begin
                if (tmr_done) begin
                    d.state = ST_IDLE;
                end
            end
            default: d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_REGS;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE) && !pd_req;
    assign mod_ready = (q.state == ST_MODIFY_WAIT);
    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rd_data;
    assign pd_ack    = q.pd_ack;
    assign mem_ce_n  = q.ce_n;
    assign mem_we_n  = q.we_n;
    assign mem_addr  = q.addr;
    assign mem_din   = q.din;

    a_r2_we_leads_ce: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ce_n) && q.op == OP_WRITE) |-> (!q.we_n && !$past(q.we_n)));

    a_r3_ce_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ce_n) && q.op != OP_WRITE) |-> q.we_n);

    a_r5_din_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.we_n && !$past(q.we_n)) |-> $stable(q.din));

    a_r6_precharge_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PRECHARGE) |-> (q.ce_n && q.we_n));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_valid |=> !q.rd_valid);

    a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ce_n && !$past(q.ce_n)) |-> $stable(q.addr));

    a_r9_standby_parked: assert property (@(posedge clk) disable iff (!rst_n)
        q.pd_ack |-> (q.ce_n && q.we_n));

    a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> !req_ready);

endmodule

// File: tb/sim_ram_cycle_seq.sv
module sim_ram_cycle_seq;

    localparam int AW = 12;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tp_setup, tp_hold, tp_access, tp_lead, tp_pre, tp_ppd, tp_rec;
    logic req_valid = 1'b0, req_ready, req_wdata = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic rd_valid, rd_data;
    logic mod_valid = 1'b0, mod_ready, mod_wdata = 1'b0;
    logic pd_req = 1'b0, pd_ack;
    logic mem_ce_n, mem_we_n, mem_din, mem_dout;
    logic [AW-1:0] mem_addr;

    always #2 clk = ~clk;

    ram_cycle_seq #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .t_setup(tp_setup), .t_hold(tp_hold), .t_access(tp_access),
        .t_lead(tp_lead), .t_precharge(tp_pre), .t_ppd(tp_ppd), .t_recover(tp_rec),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mod_valid(mod_valid), .mod_ready(mod_ready), .mod_wdata(mod_wdata),
        .pd_req(pd_req), .pd_ack(pd_ack),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_din(mem_din), .mem_dout(mem_dout)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit dev_mem [DEPTH];
    bit exp_mem [DEPTH];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int nn(input logic [CW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    // ---------------- pin-level device model and monitor ----------------
    int            cur_op  = 0;
    bit            cur_new = 1'b0;
    bit            seen_cycle = 1'b0;
    logic          ce_prev = 1'b1, we_prev = 1'b1;
    int            hi_run = 0, lo_run = 0, both_run = 0, last_low = 0;
    logic [AW-1:0] m_addr = '0;
    bit            lat = 1'b0, wrote = 1'b0, addr_ok = 1'b1;

    assign mem_dout = dev_mem[m_addr];

    always @(negedge clk) begin
        if (rst_n) begin
            if (ce_prev && !mem_ce_n) begin
                if (seen_cycle) chk(hi_run >= nn(tp_pre), "R6 ce high between cycles", hi_run, nn(tp_pre));
                seen_cycle = 1'b1;
                if (cur_op == 1)
                    chk(!we_prev && !mem_we_n, "R2 we low before ce falls", {we_prev, mem_we_n}, 0);
                else
                    chk(mem_we_n == 1'b1, "R3 we high at ce fall", mem_we_n, 1);
                m_addr  = mem_addr;
                addr_ok = 1'b1;
                lo_run  = 1;
                wrote   = 1'b0;
                both_run = 0;
                if (!mem_we_n) begin
                    lat   = mem_din;
                    wrote = 1'b1;
                end
            end else if (!mem_ce_n) begin
                lo_run++;
                if (mem_addr != m_addr) addr_ok = 1'b0;
                if (we_prev && !mem_we_n) begin
                    chk(lo_run > nn(tp_hold) + nn(tp_access), "R3 we falls after access", lo_run,
                        nn(tp_hold) + nn(tp_access) + 1);
                    chk(mem_din == cur_new, "R5 din at we fall", mem_din, cur_new);
                    lat   = mem_din;
                    wrote = 1'b1;
                end
            end else if (!ce_prev && mem_ce_n) begin
                last_low = lo_run;
                chk(addr_ok, "R8 address stable while ce low", addr_ok, 1);
                if (wrote) begin
                    chk(both_run >= nn(tp_lead), "R5 we lead before ce rise", both_run, nn(tp_lead));
                    dev_mem[m_addr] = lat;
                end
                wrote  = 1'b0;
                hi_run = 1;
            end else begin
                hi_run++;
            end
            if (!mem_ce_n && !mem_we_n) both_run++;
            ce_prev = mem_ce_n;
            we_prev = mem_we_n;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    // ---------------- host tasks ----------------
    task automatic handshake_req(input int op, input logic [AW-1:0] a, input bit wd);
        bit r;
        req_op = op[1:0]; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        forever begin
            r = req_ready;
            @(negedge clk);
            if (r) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic do_op(input int op, input logic [AW-1:0] a, input bit wd, input int dly, input bit nb);
        bit r;
        int exp_low;
        cur_op  = op;
        cur_new = (op == 1) ? wd : nb;
        @(negedge clk);
        handshake_req(op, a, wd);
        if (op != 1) begin
            while (!rd_valid) @(negedge clk);
            chk(rd_data == exp_mem[a], "R7 read data", rd_data, exp_mem[a]);
            @(negedge clk);
            chk(!rd_valid, "R7 rd_valid one cycle", rd_valid, 0);
            if (op == 2) begin
                repeat (dly - 1) @(negedge clk);
                mod_wdata = nb; mod_valid = 1'b1;
                forever begin
                    r = mod_ready;
                    @(negedge clk);
                    if (r) break;
                end
                mod_valid = 1'b0;
            end
        end
        if (op == 1) exp_mem[a] = wd;
        if (op == 2) exp_mem[a] = nb;
        while (!req_ready) @(negedge clk);
        if (op == 1)      exp_low = nn(tp_hold) + nn(tp_lead);
        else if (op == 2) exp_low = nn(tp_hold) + nn(tp_access) + dly + 1 + nn(tp_lead);
        else              exp_low = nn(tp_hold) + nn(tp_access);
        chk(last_low == exp_low, "R4 ce low length", last_low, exp_low);
    endtask

    task automatic set_timing(input int s, input int h, input int acc, input int l,
                              input int p, input int ppd, input int rc);
        tp_setup = CW'(s); tp_hold = CW'(h); tp_access = CW'(acc); tp_lead = CW'(l);
        tp_pre = CW'(p); tp_ppd = CW'(ppd); tp_rec = CW'(rc);
    endtask

    task automatic power_cycle(input bit from_idle);
        int cnt = 0;
        bit ce_ok = 1'b1;
        pd_req = 1'b1;
        forever begin
            @(negedge clk);
            if (!mem_ce_n && cnt > 0 && from_idle) ce_ok = 1'b0;
            if (pd_ack) break;
            cnt++;
        end
        if (from_idle) begin
            chk(cnt == nn(tp_ppd), "R9 ack after guard", cnt, nn(tp_ppd));
            chk(ce_ok, "R9 ce high during guard", ce_ok, 1);
        end
        req_valid = 1'b1; req_op = 2'd1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n && pd_ack, "R9 standby ignores requests",
                {req_ready, mem_ce_n, pd_ack}, 3'b011);
        end
        req_valid = 1'b0;
        pd_req = 1'b0;
        cnt = 0; ce_ok = 1'b1;
        forever begin
            @(negedge clk);
            if (!mem_ce_n || pd_ack) ce_ok = 1'b0;
            if (req_ready) break;
            cnt++;
        end
        chk(cnt == nn(tp_rec), "R10 recovery length", cnt, nn(tp_rec));
        chk(ce_ok, "R10 ce high, ack low in recovery", ce_ok, 1);
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        for (int i = 0; i < DEPTH; i++) begin
            dev_mem[i] = 1'($urandom);
            exp_mem[i] = dev_mem[i];
        end
        set_timing(2, 1, 3, 2, 2, 4, 5);
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && !pd_ack && !rd_valid, "R1 reset outputs",
            {mem_ce_n, mem_we_n, pd_ack, rd_valid}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && req_ready && !pd_ack, "R1 state after reset",
            {mem_ce_n, mem_we_n, req_ready, pd_ack}, 4'b1110);

        // directed: each op at the address extremes
        do_op(1, '0, 1'b1, 0, 1'b0);
        do_op(0, '0, 1'b0, 0, 1'b0);
        do_op(1, '1, 1'b0, 0, 1'b0);
        do_op(0, '1, 1'b0, 0, 1'b0);
        do_op(2, '1, 1'b0, 3, 1'b1);
        do_op(3, '1, 1'b0, 0, 1'b0);
        // directed: all timings zero saturate to one cycle
        set_timing(0, 0, 0, 0, 0, 0, 0);
        do_op(2, 12'd5, 1'b0, 1, 1'b0);
        do_op(1, 12'd6, 1'b1, 0, 1'b0);
        do_op(0, 12'd6, 1'b0, 0, 1'b0);
        power_cycle(1'b1);

        // directed: power-down raised mid-write
        set_timing(3, 2, 3, 2, 3, 4, 6);
        cur_op = 1; cur_new = 1'b1;
        @(negedge clk);
        handshake_req(1, 12'd77, ~exp_mem[77]);
        exp_mem[77] = ~exp_mem[77];
        power_cycle(1'b0);
        chk(last_low == nn(tp_hold) + nn(tp_lead), "R11 cycle finished before parking",
            last_low, nn(tp_hold) + nn(tp_lead));
        do_op(0, 12'd77, 1'b0, 0, 1'b0);

        // constrained random traffic
        for (int blk = 0; blk < 6; blk++) begin
            set_timing($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5,
                       $urandom % 5, 1 + $urandom % 6, 1 + $urandom % 6);
            for (int k = 0; k < 50; k++) begin
                int op;
                logic [AW-1:0] a;
                op = $urandom % 4;
                a  = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 32);
                do_op(op, a, 1'($urandom), 1 + $urandom % 4, 1'($urandom));
            end
            power_cycle(1'b1);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule